// File: doc/BRIEF.md
# Frame Key Store

This block holds a small key record for every physical page frame of main memory. Each record carries an access-control key and two usage flags. The referenced flag records that the frame has been touched since it was last cleared. The modified flag records that the frame has been written. Because the flags belong to the frame and not to any page table entry, every mapping of a frame sees the same usage history. Ordinary accesses do not need to write page tables to keep the flags current.

Two access ports report traffic: one from the processor and one from I/O channel (DMA) transfers. Each gives a frame number and a write flag, and both ports update the flags in the same way. A command port lets system software clear the referenced flag, load a new key (and optionally clear the modified flag), or read a record back into a result register. Page-replacement code typically samples and clears the referenced flag periodically, and consults the modified flag to decide whether a frame must be written back before reuse.

Top module: `fkey_store_array`

## Requirements
- R1: After reset every record has key 0, referenced 0 and modified 0, and the result outputs (`rd_vld`, `rd_key`, `rd_ref`, `rd_chg`) are all 0.
- R2: Command code 1 (clear-referenced) sets the referenced flag of the addressed frame to 0 and leaves its key and modified flag unchanged.
- R3: Command code 2 (load-key) writes `cmd_key` into the addressed frame's key. It sets the modified flag to 0 when `cmd_clr_chg` is 1 and keeps it when `cmd_clr_chg` is 0. The referenced flag is kept.
- R4: Command code 3 (read-record) makes `rd_vld` 1 for exactly the following cycle. `rd_key`/`rd_ref`/`rd_chg` then show the addressed record as it stood before that cycle's updates, and they hold that value until the next read-record.
- R5: Any processor or DMA access, read or write, sets the referenced flag of its frame to 1.
- R6: A write access (`*_wr`=1) sets the modified flag of its frame to 1. A read access leaves the modified flag unchanged.
- R7: When a command and an access hit the same frame in one cycle, the command takes effect first and the access's flag settings are applied on top, so no flag the access sets is lost.
- R8: Processor and DMA accesses in the same cycle are both applied, to different frames or to the same frame. When both hit the same frame, it receives the union of both ports' flag settings.
- R9: A frame not addressed by any valid command or access keeps its whole record.
- R10: A command with `cmd_vld`=0, or with code 0 (no operation), changes no record and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_vld | input | 1 | Processor access valid |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_frame | input | 6 | Processor access frame number |
| dma_vld | input | 1 | DMA access valid |
| dma_wr | input | 1 | DMA access is a write |
| dma_frame | input | 6 | DMA access frame number |
| cmd_vld | input | 1 | Command valid |
| cmd_op | input | 2 | Command code: 0 none, 1 clear-referenced, 2 load-key, 3 read-record |
| cmd_frame | input | 6 | Command frame number |
| cmd_key | input | 4 | Key value for load-key |
| cmd_clr_chg | input | 1 | Load-key also clears the modified flag |
| rd_vld | output | 1 | Result valid, one cycle after read-record |
| rd_key | output | 4 | Result key |
| rd_ref | output | 1 | Result referenced flag |
| rd_chg | output | 1 | Result modified flag |

## Verification
The assertions assume frame numbers lie inside the array. With the default of 64 frames this always holds, because every 6-bit value is a valid frame. They also assume the inputs are stable around the clock edge. The bench drives every input on the falling edge and draws frame numbers only from 0 to 63. The per-record assertions hold for any mix of commands and accesses, so the randomized phase is free to collide commands with both access ports on one frame.

// File: rtl/fkey_pkg.sv
package fkey_pkg;

  localparam int FK_KEY_W = 4;

  typedef enum logic [1:0] {
    FK_NOP     = 2'd0,
    FK_CLR_REF = 2'd1,
    FK_SET_KEY = 2'd2,
    FK_READ    = 2'd3
  } fk_op_e;

  typedef struct packed {
    logic [FK_KEY_W-1:0] key;
    logic                refb;
    logic                chg;
  } fk_rec_t;

  // Command step of a record update: applied before access merging.
  function automatic fk_rec_t fk_apply_cmd(fk_rec_t r, logic hit, fk_op_e op,
                                           logic [FK_KEY_W-1:0] k, logic clr_chg);
    fk_rec_t o;
    o = r;
    if (hit) begin
      case (op)
        FK_CLR_REF: o.refb = 1'b0;
        FK_SET_KEY: begin
          o.key = k;
          if (clr_chg) o.chg = 1'b0;
        end
        default: o = r;
      endcase
    end
    return o;
  endfunction

  // Access step: flags only ever get set here.
  function automatic fk_rec_t fk_merge_access(fk_rec_t r, logic touched, logic dirtied);
    fk_rec_t o;
    o      = r;
    o.refb = r.refb | touched;
    o.chg  = r.chg | dirtied;
    return o;
  endfunction

endpackage

// File: rtl/fkey_onehot.sv
module fkey_onehot #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic         vld,
  input  logic [W-1:0] idx,
  output logic [N-1:0] sel
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign sel[g] = vld && (idx == W'(g));
  end
endmodule

// File: rtl/fkey_entry.sv
module fkey_entry
  import fkey_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_hit,
  input  logic                cpu_wr,
  input  logic                dma_hit,
  input  logic                dma_wr,
  input  logic                cmd_hit,
  input  fk_op_e              cmd_op,
  input  logic [FK_KEY_W-1:0] cmd_key,
  input  logic                cmd_clr_chg,
  output fk_rec_t             rec
);
  fk_rec_t rec_q;
  fk_rec_t after_cmd;
  fk_rec_t rec_nxt;
  logic    acc_touch;
  logic    acc_dirty;

  assign acc_touch = cpu_hit | dma_hit;
  assign acc_dirty = (cpu_hit & cpu_wr) | (dma_hit & dma_wr);

  always_comb begin
    after_cmd = fk_apply_cmd(rec_q, cmd_hit, cmd_op, cmd_key, cmd_clr_chg);
    rec_nxt   = fk_merge_access(after_cmd, acc_touch, acc_dirty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_q <= '0;
    else        rec_q <= rec_nxt;
  end

  assign rec = rec_q;

  a_r5_access_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    acc_touch |=> rec_q.refb);

  a_r6_write_sets_chg: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dirty |=> rec_q.chg);

  a_r6_read_keeps_chg: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_dirty && !(cmd_hit && cmd_op == FK_SET_KEY)) |=> rec_q.chg == $past(rec_q.chg));

  a_r2_clear_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == FK_CLR_REF && !acc_touch) |=>
      (!rec_q.refb && $stable(rec_q.key) && $stable(rec_q.chg)));

  a_r3_key_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == FK_SET_KEY) |=> rec_q.key == $past(cmd_key));

  a_r7_cmd_then_access: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && acc_touch) |=> rec_q.refb);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_touch && !cmd_hit) |=> $stable(rec_q));

  a_r10_nop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == FK_NOP && !acc_touch) |=> $stable(rec_q));
endmodule

// File: rtl/fkey_readout.sv
module fkey_readout
  import fkey_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [W-1:0]     rd_frame,
  input  fk_rec_t [N-1:0]  recs,
  output logic             rd_vld,
  output fk_rec_t          rd_rec
);
  fk_rec_t picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_frame == W'(i)) picked = recs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_rec <= '0;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) rd_rec <= picked;
    end
  end

  a_r4_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_vld);

  a_r4_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_rec));
endmodule

// File: rtl/fkey_store_array.sv
module fkey_store_array
  import fkey_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  localparam int FRAME_W = $clog2(NUM_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_vld,
  input  logic                cpu_wr,
  input  logic [FRAME_W-1:0]  cpu_frame,
  input  logic                dma_vld,
  input  logic                dma_wr,
  input  logic [FRAME_W-1:0]  dma_frame,
  input  logic                cmd_vld,
  input  logic [1:0]          cmd_op,
  input  logic [FRAME_W-1:0]  cmd_frame,
  input  logic [FK_KEY_W-1:0] cmd_key,
  input  logic                cmd_clr_chg,
  output logic                rd_vld,
  output logic [FK_KEY_W-1:0] rd_key,
  output logic                rd_ref,
  output logic                rd_chg
);
  fk_op_e                     op_e;
  logic [NUM_FRAMES-1:0]      cpu_sel;
  logic [NUM_FRAMES-1:0]      dma_sel;
  logic [NUM_FRAMES-1:0]      cmd_sel;
  logic                       rd_req;
  fk_rec_t [NUM_FRAMES-1:0]   recs;
  fk_rec_t                    rd_rec;

  assign op_e   = fk_op_e'(cmd_op);
  assign rd_req = cmd_vld && (op_e == FK_READ);

  fkey_onehot #(.N(NUM_FRAMES), .W(FRAME_W)) u_cpu_dec (
    .vld(cpu_vld), .idx(cpu_frame), .sel(cpu_sel));
  fkey_onehot #(.N(NUM_FRAMES), .W(FRAME_W)) u_dma_dec (
    .vld(dma_vld), .idx(dma_frame), .sel(dma_sel));
  fkey_onehot #(.N(NUM_FRAMES), .W(FRAME_W)) u_cmd_dec (
    .vld(cmd_vld), .idx(cmd_frame), .sel(cmd_sel));

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    fkey_entry u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_hit    (cpu_sel[f]),
      .cpu_wr     (cpu_wr),
      .dma_hit    (dma_sel[f]),
      .dma_wr     (dma_wr),
      .cmd_hit    (cmd_sel[f]),
      .cmd_op     (op_e),
      .cmd_key    (cmd_key),
      .cmd_clr_chg(cmd_clr_chg),
      .rec        (recs[f])
    );
  end

  fkey_readout #(.N(NUM_FRAMES), .W(FRAME_W)) u_readout (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_frame(cmd_frame),
    .recs    (recs),
    .rd_vld  (rd_vld),
    .rd_rec  (rd_rec)
  );

  assign rd_key = rd_rec.key;
  assign rd_ref = rd_rec.refb;
  assign rd_chg = rd_rec.chg;

  a_r8_both_ports_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vld && dma_vld && !cmd_vld) |=> (recs[$past(cpu_frame)].refb && recs[$past(dma_frame)].refb));

  a_r10_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !rd_vld);
endmodule

// File: tb/fkey_store_array_tb_top.sv
module fkey_store_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 64;
  localparam int WATCHDOG = 50000;

  typedef struct {
    logic [3:0] key;
    logic       refb;
    logic       chg;
    int         due;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_vld, cpu_wr, dma_vld, dma_wr, cmd_vld, cmd_clr_chg;
  logic [5:0] cpu_frame, dma_frame, cmd_frame;
  logic [1:0] cmd_op;
  logic [3:0] cmd_key;
  logic       rd_vld, rd_ref, rd_chg;
  logic [3:0] rd_key;

  logic [3:0] m_key [NF];
  logic       m_ref [NF];
  logic       m_chg [NF];
  exp_t       sb_q [$];
  exp_t       last_exp;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fkey_store_array dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_vld(cpu_vld), .cpu_wr(cpu_wr), .cpu_frame(cpu_frame),
    .dma_vld(dma_vld), .dma_wr(dma_wr), .dma_frame(dma_frame),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_frame(cmd_frame),
    .cmd_key(cmd_key), .cmd_clr_chg(cmd_clr_chg),
    .rd_vld(rd_vld), .rd_key(rd_key), .rd_ref(rd_ref), .rd_chg(rd_chg)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Monitor: compares results against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rd_vld === 1'b1 && rd_key === e.key && rd_ref === e.refb && rd_chg === e.chg,
            e.tag,
            $sformatf("vld=%b key=%0d ref=%b chg=%b", rd_vld, rd_key, rd_ref, rd_chg),
            $sformatf("vld=1 key=%0d ref=%b chg=%b", e.key, e.refb, e.chg));
        last_exp = e;
      end else if (rd_vld !== 1'b0) begin
        chk(1'b0, "R4/R10 spurious result", $sformatf("vld=%b", rd_vld), "vld=0");
      end
    end
  end

  task automatic idle_inputs();
    cpu_vld = 0; cpu_wr = 0; cpu_frame = '0;
    dma_vld = 0; dma_wr = 0; dma_frame = '0;
    cmd_vld = 0; cmd_op = '0; cmd_frame = '0; cmd_key = '0; cmd_clr_chg = 0;
  endtask

  task automatic begin_cycle();
    @(negedge clk);
    idle_inputs();
  endtask

  // Driver: update the reference model for the inputs now applied
  task automatic commit(input string tag);
    exp_t e;
    int   f;
    f = int'(cmd_frame);
    if (cmd_vld && cmd_op == 2'd3) begin
      e.key = m_key[f]; e.refb = m_ref[f]; e.chg = m_chg[f];
      e.due = cyc + 1; e.tag = tag;
      sb_q.push_back(e);
    end
    if (cmd_vld && cmd_op == 2'd1) m_ref[f] = 1'b0;
    if (cmd_vld && cmd_op == 2'd2) begin
      m_key[f] = cmd_key;
      if (cmd_clr_chg) m_chg[f] = 1'b0;
    end
    if (cpu_vld) begin
      m_ref[int'(cpu_frame)] = 1'b1;
      if (cpu_wr) m_chg[int'(cpu_frame)] = 1'b1;
    end
    if (dma_vld) begin
      m_ref[int'(dma_frame)] = 1'b1;
      if (dma_wr) m_chg[int'(dma_frame)] = 1'b1;
    end
  endtask

  task automatic tick(input string tag);
    commit(tag);
  endtask

  task automatic read_frame(input int f, input string tag);
    begin_cycle();
    cmd_vld = 1; cmd_op = 2'd3; cmd_frame = 6'(f);
    tick(tag);
  endtask

  task automatic flush();
    repeat (3) begin begin_cycle(); tick("idle"); end
  endtask

  initial begin
    for (int i = 0; i < NF; i++) begin m_key[i] = '0; m_ref[i] = 0; m_chg[i] = 0; end
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_vld === 0 && rd_key === 0 && rd_ref === 0 && rd_chg === 0, "R1 outputs in reset",
        $sformatf("%b %0d %b %b", rd_vld, rd_key, rd_ref, rd_chg), "0 0 0 0");
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_vld === 0 && rd_key === 0, "R1 outputs after reset",
        $sformatf("%b %0d", rd_vld, rd_key), "0 0");

    read_frame(0, "R1 frame 0 zero");
    read_frame(63, "R1 frame 63 zero");

    // R5 / R6: processor read touches only the referenced flag
    begin_cycle(); cpu_vld = 1; cpu_frame = 6'd3; tick("R5 cpu read");
    read_frame(3, "R5 R6 cpu read sets ref only");
    // DMA write
    begin_cycle(); dma_vld = 1; dma_wr = 1; dma_frame = 6'd10; tick("R6 dma write");
    read_frame(10, "R5 R6 dma write sets both");

    // R8: both ports, different frames and same frame
    begin_cycle(); cpu_vld = 1; cpu_wr = 1; cpu_frame = 6'd20;
    dma_vld = 1; dma_frame = 6'd21; tick("R8");
    read_frame(20, "R8 cpu side");
    read_frame(21, "R8 dma side");
    begin_cycle(); cpu_vld = 1; cpu_frame = 6'd30;
    dma_vld = 1; dma_wr = 1; dma_frame = 6'd30; tick("R8");
    read_frame(30, "R8 same frame union");

    // R3: load key, with and without modified clear
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd2; cmd_frame = 6'd10; cmd_key = 4'd9; tick("R3");
    read_frame(10, "R3 key load keeps chg");
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd2; cmd_frame = 6'd10; cmd_key = 4'd5;
    cmd_clr_chg = 1; tick("R3");
    read_frame(10, "R3 key load clears chg");

    // R2: clear referenced
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd1; cmd_frame = 6'd10; tick("R2");
    read_frame(10, "R2 clear ref frame 10");
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd1; cmd_frame = 6'd20; tick("R2");
    read_frame(20, "R2 clear ref keeps chg");

    // R10: no-op code and invalid command
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd0; cmd_frame = 6'd3; tick("R10");
    begin_cycle(); cmd_vld = 0; cmd_op = 2'd1; cmd_frame = 6'd3; tick("R10");
    begin_cycle(); cmd_vld = 0; cmd_op = 2'd2; cmd_frame = 6'd3; cmd_key = 4'hF; tick("R10");
    read_frame(3, "R10 frame 3 untouched");

    // R7: command and access on one frame in one cycle
    begin_cycle(); cpu_vld = 1; cpu_wr = 1; cpu_frame = 6'd40; tick("R7 setup");
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd1; cmd_frame = 6'd40;
    cpu_vld = 1; cpu_frame = 6'd40; tick("R7");
    read_frame(40, "R7 clear ref then access sets ref");
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd2; cmd_frame = 6'd40; cmd_key = 4'd7; cmd_clr_chg = 1;
    dma_vld = 1; dma_wr = 1; dma_frame = 6'd40; tick("R7");
    read_frame(40, "R7 clear chg then write sets chg");

    // R4: read sees pre-update record, then the updated one
    begin_cycle(); cmd_vld = 1; cmd_op = 2'd3; cmd_frame = 6'd50;
    cpu_vld = 1; cpu_wr = 1; cpu_frame = 6'd50; tick("R4 read before same-cycle write");
    read_frame(50, "R4 read after write");
    flush();
    chk(rd_key === last_exp.key && rd_ref === last_exp.refb && rd_chg === last_exp.chg,
        "R4 result holds",
        $sformatf("key=%0d ref=%b chg=%b", rd_key, rd_ref, rd_chg),
        $sformatf("key=%0d ref=%b chg=%b", last_exp.key, last_exp.refb, last_exp.chg));

    // R9: frames never addressed
    read_frame(1, "R9 frame 1 untouched");
    read_frame(62, "R9 frame 62 untouched");

    // Randomized mix, frequently colliding
    for (int n = 0; n < 600; n++) begin
      begin_cycle();
      cpu_vld = ($urandom_range(0, 2) != 0); cpu_wr = $urandom_range(0, 1) == 1;
      cpu_frame = 6'($urandom_range(0, 7));
      dma_vld = ($urandom_range(0, 2) == 0); dma_wr = $urandom_range(0, 1) == 1;
      dma_frame = 6'($urandom_range(0, 7));
      cmd_vld = ($urandom_range(0, 1) == 1); cmd_op = 2'($urandom_range(0, 3));
      cmd_frame = 6'($urandom_range(0, 7)); cmd_key = 4'($urandom_range(0, 15));
      cmd_clr_chg = $urandom_range(0, 1) == 1;
      tick("R5 R7 R8 random mix");
    end
    for (int f = 0; f < 8; f++) read_frame(f, "R9 random final sweep");
    flush();
    chk(sb_q.size() == 0, "R4 all results delivered", $sformatf("%0d", sb_q.size()), "0");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait (cyc > WATCHDOG);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=end of test", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule